// File: doc/BRIEF.md
# Transmit Descriptor Ring DMA Engine

This block moves outgoing frames from memory to a byte-stream transmitter. Software keeps a contiguous ring of descriptors, each four 32-bit words placed back to back. To queue a frame, software fills in a descriptor, sets its ownership bit and writes the poll register. The engine reads the ownership word and then the buffer address and length words. It streams the buffer bytes out, writes the ownership word back with ownership cleared, and moves to the next ring slot. After the last slot it wraps to the ring base.

When the engine reaches a descriptor that software still owns, it raises a buffer-unavailable status and suspends. It stays suspended until software writes the poll register; the same slot is then fetched again. A completion status is raised for each descriptor that asks for one. Both statuses are write-1-to-clear and feed a sticky summary flag that drives the interrupt line.

The controller moves through these states:

- `S_IDLE` waits for the start bit.
- `S_OWN_RD` reads word 3 and checks ownership.
- `S_ADDR_RD` reads word 0.
- `S_LEN_RD` reads word 2.
- `S_BUF_RD` reads one buffer word.
- `S_SEND` offers bytes.
- `S_WBACK` writes word 3 back.
- `S_SUSP` waits for a poll.

The transitions are:

- `S_IDLE` goes to `S_OWN_RD` when start is set.
- From `S_OWN_RD`, an owned descriptor leads to `S_ADDR_RD`; an unowned one leads to `S_SUSP`.
- `S_ADDR_RD` goes to `S_LEN_RD`.
- From `S_LEN_RD`, a zero length leads to `S_WBACK`; otherwise the engine goes to `S_BUF_RD`.
- `S_BUF_RD` goes to `S_SEND`.
- From `S_SEND`, the last byte leads to `S_WBACK`. Crossing a word boundary leads back to `S_BUF_RD`. Otherwise the engine stays in `S_SEND`.
- From `S_WBACK`, the engine goes to `S_OWN_RD` if start is set, or to `S_IDLE` if it is not.
- From `S_SUSP`, a poll leads to `S_OWN_RD`, and clearing start leads to `S_IDLE`.

Top module: `txdesc_dma`

## Requirements
- R1: After reset the status register reads 0, irq is low, tx_valid is low and mem_req is low; no memory access happens until the start bit (bit 0 of register 0) is set.
- R2: Descriptor n of the ring sits at base + 16*n. Word 0 is the buffer address, word 2 holds the length in bits 13:0 and the completion request in bit 31, and word 3 holds ownership in bit 31. After the descriptor whose index equals the ring-size register (register 2, count minus one), the next one used is index 0.
- R3: When the fetched word 3 has bit 31 clear, status bit 1 (buffer unavailable) is set. The engine then emits no byte and makes no further memory access until it is polled.
- R4: A write of any value to register 3 while suspended makes the engine fetch the same descriptor again and continue if that descriptor is now owned.
- R5: The bytes of a buffer come out in rising address order, starting at the word-0 address (any byte alignment). Exactly length bytes are sent, and tx_last is high on the final one only.
- R6: A descriptor with length 0 emits no byte but is still written back and completes.
- R7: On completion the engine writes only word 3, with bit 31 cleared and every other bit unchanged.
- R8: Status bit 0 (transmit complete) is set when a descriptor with word-2 bit 31 set is written back, and is not set by one without it.
- R9: Status bits (register 4) clear when written with 1 and stay when written with 0. Bit 2 is set whenever bit 0 or bit 1 is set, and it is cleared only by writing 1. The irq output equals bit 2.
- R10: With start cleared, the engine finishes the descriptor in progress and then stays idle, ignoring polls. Setting start again resumes at the current descriptor.
- R11: Writing the base register (register 1) resets the current descriptor index to 0.
- R12: mem_req, mem_we and mem_addr hold steady until mem_ack. tx_valid, tx_data and tx_last hold steady until tx_ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select for write and read |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the selected register |
| irq | output | 1 | Summary interrupt |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | 32 | Byte address, word aligned |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Access completes this cycle |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| tx_valid | output | 1 | Byte offered |
| tx_data | output | 8 | Byte value |
| tx_last | output | 1 | Final byte of the frame |
| tx_ready | input | 1 | Byte accepted this cycle |

## Verification
- **Memory accesses:** Every access takes effect at the clock edge after the memory model acknowledges it on the preceding falling edge.
- **Bytes:** Each byte transfer is recorded on the falling edge before the rising edge that moves it. The scoreboard therefore compares bytes and write-backs in the cycle they are committed.
- **Status bits:** A status bit is visible one edge after the write-back or ownership read that raises it. A status clear is visible one edge after the register write, so register reads happen on the falling edge after that edge.
- **Whole runs:** Multi-descriptor runs are awaited by polling for the buffer-unavailable bit. The queues are checked empty only after that bit appears.

// File: rtl/txr_pkg.sv
package txr_pkg;

    // descriptor word byte offsets and bit positions
    localparam logic [31:0] OFS_BUFADDR = 32'd0;
    localparam logic [31:0] OFS_LENCTL  = 32'd8;
    localparam logic [31:0] OFS_FLAGS   = 32'd12;
    localparam int unsigned OWN_BIT     = 31;
    localparam int unsigned IOC_BIT     = 31;

    // register selects
    localparam logic [2:0] REG_CTRL = 3'd0;
    localparam logic [2:0] REG_BASE = 3'd1;
    localparam logic [2:0] REG_RLEN = 3'd2;
    localparam logic [2:0] REG_POLL = 3'd3;
    localparam logic [2:0] REG_STAT = 3'd4;

    // status bit positions
    localparam int unsigned ST_DONE = 0;
    localparam int unsigned ST_UNAV = 1;
    localparam int unsigned ST_SUM  = 2;

    typedef enum logic [2:0] {
        S_IDLE,
        S_OWN_RD,
        S_ADDR_RD,
        S_LEN_RD,
        S_BUF_RD,
        S_SEND,
        S_WBACK,
        S_SUSP
    } txr_state_e;

endpackage

// File: rtl/txr_regs.sv
module txr_regs
    import txr_pkg::*;
#(
    parameter int unsigned IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [2:0]       addr,
    input  logic [31:0]      wdata,
    output logic [31:0]      rdata,
    input  logic             ev_done,
    input  logic             ev_unav,
    output logic             start_o,
    output logic [31:0]      base_o,
    output logic [IDX_W-1:0] rlen_o,
    output logic             poll_o,
    output logic             base_wr_o,
    output logic             irq_o
);

    localparam int unsigned PAD_W = 32 - IDX_W;

    logic             start_q;
    logic [31:2]      base_q;
    logic [IDX_W-1:0] rlen_q;
    logic [2:0]       stat_q;
    logic [2:0]       stat_clr;
    logic [2:0]       stat_set;

    always_comb begin
        stat_clr = (wr_en && addr == REG_STAT) ? wdata[2:0] : 3'b000;
        stat_set = 3'b000;
        stat_set[ST_DONE] = ev_done;
        stat_set[ST_UNAV] = ev_unav;
        stat_set[ST_SUM]  = ev_done | ev_unav;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q <= 1'b0;
            base_q  <= '0;
            rlen_q  <= '0;
            stat_q  <= '0;
        end else begin
            if (wr_en && addr == REG_CTRL) start_q <= wdata[0];
            if (wr_en && addr == REG_BASE) base_q  <= wdata[31:2];
            if (wr_en && addr == REG_RLEN) rlen_q  <= wdata[IDX_W-1:0];
            stat_q <= (stat_q & ~stat_clr) | stat_set;
        end
    end

    always_comb begin
        unique case (addr)
            REG_CTRL: rdata = {31'd0, start_q};
            REG_BASE: rdata = {base_q, 2'b00};
            REG_RLEN: rdata = {{PAD_W{1'b0}}, rlen_q};
            REG_STAT: rdata = {29'd0, stat_q};
            default:  rdata = 32'd0;
        endcase
    end

    assign start_o   = start_q;
    assign base_o    = {base_q, 2'b00};
    assign rlen_o    = rlen_q;
    assign poll_o    = wr_en && addr == REG_POLL;
    assign base_wr_o = wr_en && addr == REG_BASE;
    assign irq_o     = stat_q[ST_SUM];

endmodule

// File: rtl/txr_ring_ptr.sv
module txr_ring_ptr #(
    parameter int unsigned IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             advance,
    input  logic [IDX_W-1:0] rlen,
    input  logic [31:0]      base,
    output logic [IDX_W-1:0] idx_o,
    output logic [31:0]      desc_addr_o
);

    localparam int unsigned SLOT_SH = 4;
    localparam int unsigned PAD_W   = 32 - IDX_W - SLOT_SH;

    logic [IDX_W-1:0] idx_q;

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            idx_q <= '0;
        end else if (advance) begin
            idx_q <= (idx_q >= rlen) ? '0 : idx_q + 1'b1;
        end
    end

    assign idx_o       = idx_q;
    assign desc_addr_o = base + {{PAD_W{1'b0}}, idx_q, {SLOT_SH{1'b0}}};

endmodule

// File: rtl/txr_fsm.sv
module txr_fsm
    import txr_pkg::*;
#(
    parameter int unsigned LEN_W = 14
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        poll,
    input  logic [31:0] desc_addr,
    output logic        mem_req,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata,
    input  logic        mem_ack,
    input  logic [31:0] mem_rdata,
    output logic        tx_valid,
    output logic [7:0]  tx_data,
    output logic        tx_last,
    input  logic        tx_ready,
    output logic        ev_done,
    output logic        ev_unav,
    output logic        advance
);

    localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

    txr_state_e        state_q, state_d;
    logic              pend_q;
    logic [31:0]       w3_q;
    logic              ioc_q;
    logic [31:0]       cur_q;
    logic [LEN_W-1:0]  rem_q;
    logic [31:0]       word_q;
    logic              owned;
    logic              len_zero;

    assign owned    = mem_rdata[OWN_BIT];
    assign len_zero = mem_rdata[LEN_W-1:0] == '0;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:    if (start) state_d = S_OWN_RD;
            S_OWN_RD:  if (mem_ack) state_d = owned ? S_ADDR_RD : S_SUSP;
            S_ADDR_RD: if (mem_ack) state_d = S_LEN_RD;
            S_LEN_RD:  if (mem_ack) state_d = len_zero ? S_WBACK : S_BUF_RD;
            S_BUF_RD:  if (mem_ack) state_d = S_SEND;
            S_SEND: begin
                if (tx_ready) begin
                    if (rem_q == ONE)            state_d = S_WBACK;
                    else if (cur_q[1:0] == 2'b11) state_d = S_BUF_RD;
                    else                          state_d = S_SEND;
                end
            end
            S_WBACK:   if (mem_ack) state_d = start ? S_OWN_RD : S_IDLE;
            S_SUSP: begin
                if (!start)      state_d = S_IDLE;
                else if (pend_q) state_d = S_OWN_RD;
            end
            default:   state_d = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = 32'd0;
        mem_wdata = 32'd0;
        tx_valid  = 1'b0;
        tx_last   = 1'b0;
        ev_done   = 1'b0;
        ev_unav   = 1'b0;
        advance   = 1'b0;
        unique case (state_q)
            S_OWN_RD: begin
                mem_req  = 1'b1;
                mem_addr = desc_addr + OFS_FLAGS;
                ev_unav  = mem_ack && !owned;
            end
            S_ADDR_RD: begin
                mem_req  = 1'b1;
                mem_addr = desc_addr + OFS_BUFADDR;
            end
            S_LEN_RD: begin
                mem_req  = 1'b1;
                mem_addr = desc_addr + OFS_LENCTL;
            end
            S_BUF_RD: begin
                mem_req  = 1'b1;
                mem_addr = {cur_q[31:2], 2'b00};
            end
            S_SEND: begin
                tx_valid = 1'b1;
                tx_last  = rem_q == ONE;
            end
            S_WBACK: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = desc_addr + OFS_FLAGS;
                mem_wdata = w3_q & ~(32'd1 << OWN_BIT);
                ev_done   = mem_ack && ioc_q;
                advance   = mem_ack;
            end
            S_IDLE, S_SUSP: ;
            default: ;
        endcase
    end

    assign tx_data = word_q[{cur_q[1:0], 3'b000} +: 8];

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            w3_q   <= '0;
            ioc_q  <= 1'b0;
            cur_q  <= '0;
            rem_q  <= '0;
            word_q <= '0;
        end else begin
            if (state_q == S_OWN_RD && mem_ack)  w3_q <= mem_rdata;
            if (state_q == S_ADDR_RD && mem_ack) cur_q <= mem_rdata;
            if (state_q == S_LEN_RD && mem_ack) begin
                rem_q <= mem_rdata[LEN_W-1:0];
                ioc_q <= mem_rdata[IOC_BIT];
            end
            if (state_q == S_BUF_RD && mem_ack)  word_q <= mem_rdata;
            if (state_q == S_SEND && tx_ready) begin
                cur_q <= cur_q + 32'd1;
                rem_q <= rem_q - ONE;
            end
        end
    end

    // poll demand is remembered until the engine refetches
    always_ff @(posedge clk) begin
        if (!rst_n)
            pend_q <= 1'b0;
        else if (poll)
            pend_q <= 1'b1;
        else if ((state_q == S_SUSP || state_q == S_IDLE) && state_d == S_OWN_RD)
            pend_q <= 1'b0;
    end

endmodule

// File: rtl/txdesc_dma.sv
module txdesc_dma #(
    parameter int unsigned IDX_W = 8,
    parameter int unsigned LEN_W = 14
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [2:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        irq,
    output logic        mem_req,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata,
    input  logic        mem_ack,
    input  logic [31:0] mem_rdata,
    output logic        tx_valid,
    output logic [7:0]  tx_data,
    output logic        tx_last,
    input  logic        tx_ready
);

    logic             start;
    logic [31:0]      base;
    logic [IDX_W-1:0] rlen;
    logic             poll;
    logic             base_wr;
    logic             ev_done;
    logic             ev_unav;
    logic             advance;
    logic [IDX_W-1:0] idx;
    logic [31:0]      desc_addr;

    txr_regs #(.IDX_W(IDX_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (reg_wr),
        .addr      (reg_addr),
        .wdata     (reg_wdata),
        .rdata     (reg_rdata),
        .ev_done   (ev_done),
        .ev_unav   (ev_unav),
        .start_o   (start),
        .base_o    (base),
        .rlen_o    (rlen),
        .poll_o    (poll),
        .base_wr_o (base_wr),
        .irq_o     (irq)
    );

    txr_ring_ptr #(.IDX_W(IDX_W)) u_ring (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear       (base_wr),
        .advance     (advance),
        .rlen        (rlen),
        .base        (base),
        .idx_o       (idx),
        .desc_addr_o (desc_addr)
    );

    txr_fsm #(.LEN_W(LEN_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .poll      (poll),
        .desc_addr (desc_addr),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_ack   (mem_ack),
        .mem_rdata (mem_rdata),
        .tx_valid  (tx_valid),
        .tx_data   (tx_data),
        .tx_last   (tx_last),
        .tx_ready  (tx_ready),
        .ev_done   (ev_done),
        .ev_unav   (ev_unav),
        .advance   (advance)
    );

    logic unused_idx;
    assign unused_idx = ^idx;

endmodule

// File: rtl/txdesc_dma_chk.sv
module txdesc_dma_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        mem_req,
    input logic        mem_we,
    input logic [31:0] mem_addr,
    input logic [31:0] mem_wdata,
    input logic        mem_ack,
    input logic        tx_valid,
    input logic        tx_ready,
    input logic [7:0]  tx_data,
    input logic        tx_last,
    input logic [31:0] desc_addr
);

    assert_req_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));

    assert_byte_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_last));

    assert_wb_word3_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we |-> !mem_wdata[31] && mem_addr == desc_addr + 32'd12);

    assert_aligned_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> mem_addr[1:0] == 2'b00);

    assert_no_overlap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> !mem_req);

    assert_last_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
        tx_last |-> tx_valid);

endmodule

bind txdesc_dma txdesc_dma_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_ack   (mem_ack),
    .tx_valid  (tx_valid),
    .tx_ready  (tx_ready),
    .tx_data   (tx_data),
    .tx_last   (tx_last),
    .desc_addr (desc_addr)
);

// File: tb/sim_txdesc_dma.sv
module sim_txdesc_dma;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        reg_wr;
    logic [2:0]  reg_addr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic        irq;
    logic        mem_req;
    logic        mem_we;
    logic [31:0] mem_addr;
    logic [31:0] mem_wdata;
    logic        mem_ack;
    logic [31:0] mem_rdata;
    logic        tx_valid;
    logic [7:0]  tx_data;
    logic        tx_last;
    logic        tx_ready;

    always #4 clk = ~clk;

    txdesc_dma u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last),
        .tx_ready(tx_ready)
    );

    logic [31:0] mem [0:255];
    logic [8:0]  exp_bytes [$];
    logic [63:0] exp_wb [$];
    int          n_checks = 0;
    int          n_fails  = 0;
    bit          finished = 0;
    bit          bp_mode  = 0;
    logic [15:0] lfsr     = 16'hACE1;

    task automatic check_eq(input string req, input string what,
                            input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // memory model and byte/write-back monitor
    initial begin
        mem_ack   = 1'b0;
        mem_rdata = '0;
        tx_ready  = 1'b0;
        forever begin
            @(negedge clk);
            if (bp_mode) begin
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                tx_ready = lfsr[0];
            end else begin
                tx_ready = 1'b1;
            end
            mem_ack   = mem_req;
            mem_rdata = (mem_req && !mem_we) ? mem[mem_addr[9:2]] : 32'd0;
            if (mem_req && mem_we) begin
                if (exp_wb.size() == 0) begin
                    check_eq("R7", "unexpected write address", mem_addr, 32'hFFFF_FFFF);
                end else begin
                    logic [63:0] e;
                    e = exp_wb.pop_front();
                    check_eq("R2", "write-back address", mem_addr, e[63:32]);
                    check_eq("R7", "write-back data", mem_wdata, e[31:0]);
                end
                mem[mem_addr[9:2]] = mem_wdata;
            end
            if (tx_valid && tx_ready) begin
                if (exp_bytes.size() == 0) begin
                    check_eq("R5", "unexpected byte", {24'd0, tx_data}, 32'hFFFF_FFFF);
                end else begin
                    logic [8:0] b;
                    b = exp_bytes.pop_front();
                    check_eq("R5", "byte value", {24'd0, tx_data}, {24'd0, b[7:0]});
                    check_eq("R5", "last flag", {31'd0, tx_last}, {31'd0, b[8]});
                end
            end
        end
    end

    task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_addr = 3'd4;
    endtask

    task automatic reg_read(input logic [2:0] a, output logic [31:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
        reg_addr = 3'd4;
    endtask

    // driver: builds a descriptor and pushes what must come out
    task automatic post_desc(input logic [31:0] base, input int idx,
                             input logic [31:0] baddr, input int len,
                             input bit ioc, input logic [7:0] seed);
        logic [31:0] d;
        logic [31:0] w3;
        d  = base + 32'(idx * 16);
        w3 = 32'hB000_5A00 | 32'(idx);
        for (int i = 0; i < len; i++) begin
            logic [31:0] a;
            logic [7:0]  b;
            a = baddr + 32'(i);
            b = seed + 8'(i * 7);
            mem[a[9:2]][8*int'(a[1:0]) +: 8] = b;
            exp_bytes.push_back({(i == len - 1), b});
        end
        mem[d[9:2]]       = baddr;
        mem[d[9:2] + 8'd1] = 32'd0;
        mem[d[9:2] + 8'd2] = {ioc, 17'd0, 14'(len)};
        mem[d[9:2] + 8'd3] = w3;
        exp_wb.push_back({d + 32'd12, w3 & 32'h7FFF_FFFF});
    endtask

    task automatic wait_unav(input string req);
        bit seen;
        seen = 0;
        for (int i = 0; i < 3000 && !seen; i++) begin
            @(negedge clk);
            #1;
            if (reg_addr == 3'd4 && reg_rdata[1]) seen = 1;
        end
        check_eq(req, "suspension reached", {31'd0, seen}, 32'd1);
    endtask

    task automatic queues_empty(input string req);
        check_eq(req, "bytes outstanding", 32'(exp_bytes.size()), 32'd0);
        check_eq(req, "write-backs outstanding", 32'(exp_wb.size()), 32'd0);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog run did not complete actual=hung expected=done");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        rst_n = 1'b0; reg_wr = 1'b0; reg_addr = 3'd4; reg_wdata = '0;
        for (int i = 0; i < 256; i++) mem[i] = 32'd0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R1 reset state, engine quiet without start
        reg_read(3'd4, v);
        check_eq("R1", "status after reset", v, 32'd0);
        check_eq("R1", "irq after reset", {31'd0, irq}, 32'd0);
        check_eq("R1", "tx_valid after reset", {31'd0, tx_valid}, 32'd0);
        check_eq("R1", "mem_req after reset", {31'd0, mem_req}, 32'd0);

        // ring of 4 at 0x100; three owned descriptors, one zero length
        reg_write(3'd1, 32'h0000_0100);
        reg_write(3'd2, 32'd3);
        post_desc(32'h100, 0, 32'h200, 5, 1, 8'h10);
        post_desc(32'h100, 1, 32'h241, 7, 0, 8'h40);
        post_desc(32'h100, 2, 32'h280, 0, 1, 8'h00);
        reg_write(3'd0, 32'd1);
        wait_unav("R3");
        queues_empty("R5");
        reg_read(3'd4, v);
        check_eq("R8", "status with completions and suspension", v, 32'd7);
        check_eq("R9", "irq follows summary", {31'd0, irq}, 32'd1);
        check_eq("R7", "word 3 of slot 0 written back", mem[8'd67], 32'h3000_5A00);
        check_eq("R6", "zero-length slot written back", mem[8'd75], 32'h3000_5A02);
        repeat (10) @(negedge clk);
        check_eq("R3", "no byte while suspended", {31'd0, tx_valid}, 32'd0);
        check_eq("R3", "no access while suspended", {31'd0, mem_req}, 32'd0);

        // R9 write-1-to-clear per bit
        reg_write(3'd4, 32'd1);
        reg_read(3'd4, v);
        check_eq("R9", "clear bit 0 only", v, 32'd6);
        reg_write(3'd4, 32'd0);
        reg_read(3'd4, v);
        check_eq("R9", "write 0 keeps bits", v, 32'd6);
        reg_write(3'd4, 32'd6);
        reg_read(3'd4, v);
        check_eq("R9", "all cleared", v, 32'd0);
        check_eq("R9", "irq low after clear", {31'd0, irq}, 32'd0);

        // R4 poll resumes at slot 3, then wraps to slot 0 (R2)
        post_desc(32'h100, 3, 32'h2C0, 3, 0, 8'h70);
        reg_write(3'd3, 32'd0);
        wait_unav("R4");
        queues_empty("R4");
        reg_read(3'd4, v);
        check_eq("R8", "no completion without request", v & 32'd1, 32'd0);
        reg_write(3'd4, 32'd7);
        post_desc(32'h100, 0, 32'h2E0, 4, 0, 8'h90);
        reg_write(3'd3, 32'd0);
        wait_unav("R2");
        queues_empty("R2");

        // R12 backpressure on an unaligned buffer crossing words
        reg_write(3'd4, 32'd7);
        bp_mode = 1;
        post_desc(32'h100, 1, 32'h303, 9, 1, 8'hA0);
        reg_write(3'd3, 32'd0);
        wait_unav("R12");
        bp_mode = 0;
        queues_empty("R12");
        reg_read(3'd4, v);
        check_eq("R8", "completion requested", v & 32'd1, 32'd1);

        // R10 stop: polls ignored while start is clear
        reg_write(3'd0, 32'd0);
        repeat (5) @(negedge clk);
        reg_write(3'd4, 32'd7);
        post_desc(32'h100, 2, 32'h320, 3, 0, 8'hC0);
        reg_write(3'd3, 32'd0);
        repeat (40) @(negedge clk);
        check_eq("R10", "no bytes while stopped", 32'(exp_bytes.size()), 32'd3);
        check_eq("R10", "descriptor still owned", {31'd0, mem[8'd75][31]}, 32'd1);
        reg_write(3'd0, 32'd1);
        wait_unav("R10");
        queues_empty("R10");

        // R11 new base restarts at index 0
        reg_write(3'd0, 32'd0);
        repeat (5) @(negedge clk);
        reg_write(3'd1, 32'h0000_0180);
        reg_write(3'd2, 32'd1);
        reg_read(3'd1, v);
        check_eq("R11", "base readback", v, 32'h180);
        reg_write(3'd4, 32'd7);
        post_desc(32'h180, 0, 32'h340, 6, 1, 8'hE0);
        reg_write(3'd0, 32'd1);
        wait_unav("R11");
        queues_empty("R11");

        repeat (5) @(negedge clk);
        finish_run();
    end

endmodule